// File: doc/BRIEF.md
# Three-Phase Sample Conditioner

This block sits between the converter read-out and the metering arithmetic of a three-phase energy measurement path. It receives a byte-wide stream of 16-bit two's-complement samples. Each sample is assembled, conditioned and held per phase, so that the downstream multiply-accumulate logic always sees a clean current sample and its one-sample-old predecessor.

A frame starts with a single-cycle start strobe. It then carries twelve accepted bytes: phase A first, then B, then C. Each phase sends its voltage and then its current, high byte before low byte. While the frame runs, the block drives a one-hot converter select that moves to the next phase once the previous phase is complete, and returns to phase A at the end.

Several conditioning steps act on the data:
- A test flag swaps each incoming byte for the matching byte of a fixed voltage or current pattern.
- The single code -32768 is lifted to -32767.
- A coarse peak register per channel follows the largest magnitude of the sample high byte.

A clear pulse zeroes all peak registers.

Top module: `phase_cond_top`

## Requirements
- R1: Bytes accepted within a frame are mapped, in order, to phase A, B, C. Within each phase the order is voltage high, voltage low, current high, current low. A voltage or current output changes only on the edge that accepts its low byte, and then takes the assembled 16-bit sample.
- R2: `conv_sel` is always one-hot, with bit 0 for phase A, bit 1 for B and bit 2 for C. It reads 3'b001 after reset. On the edge that accepts the fourth byte of phase A or B it moves to the next phase, and on the edge that accepts the twelfth byte it returns to phase A.
- R3: On the edge that accepts a phase's first byte, that phase's delayed voltage and current outputs take the values its current outputs held just before.
- R4: While `test_en` is high on an accepted byte, the byte is replaced by the byte in the same position of `test_volt` (for the voltage bytes) or `test_curr` (for the current bytes). The flag is sampled byte by byte.
- R5: An assembled sample of 16'h8000 is stored as 16'h8001. No output sample ever reads 16'h8000.
- R6: On each stored sample, the high byte h of the stored (clamped) value gives the magnitude h when h[7] is 0 and ~h when h[7] is 1. The channel's peak register is overwritten with this magnitude only when it is strictly greater.
- R7: Each of the six channels (voltage and current of A, B, C) has its own independent peak register.
- R8: `peak_clr` zeroes all six peak registers on the next edge. It overrides a peak update in the same cycle.
- R9: `frame_done` is high for exactly the one cycle that follows the edge accepting the twelfth byte.
- R10: `byte_valid` has no effect outside a frame, and in the cycle in which `frame_start` is high. A `frame_start` during a frame restarts it at byte 0 with phase A selected.
- R11: Reset clears all samples, delayed samples and peaks to zero, sets `conv_sel` to 3'b001 and holds `frame_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts (or restarts) a frame |
| byte_valid | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Received serial byte |
| test_en | input | 1 | Substitute test pattern bytes |
| test_volt | input | 16 | Voltage test pattern |
| test_curr | input | 16 | Current test pattern |
| peak_clr | input | 1 | Clears all peak registers |
| conv_sel | output | 3 | One-hot converter select, bit 0 = phase A |
| volt_now | output | 3x16 | Latest voltage sample per phase |
| curr_now | output | 3x16 | Latest current sample per phase |
| volt_dly | output | 3x16 | Previous voltage sample per phase |
| curr_dly | output | 3x16 | Previous current sample per phase |
| peak_volt | output | 3x8 | Coarse voltage peak per phase |
| peak_curr | output | 3x8 | Coarse current peak per phase |
| frame_done | output | 1 | One-cycle pulse after a complete frame |

## Verification
Several properties are checked on every cycle:
- the select stays one-hot, holds between phase boundaries and falls back to phase A at frame end;
- the clamped code never appears;
- peaks never shrink without a clear, and are zero after one;
- the delayed registers copy the previous sample on the first byte of a phase;
- the done pulse lasts one cycle.

Byte routing, the byte-wise test substitution, the exact magnitudes of the one's-complement peaks, and the ignoring of bytes outside a frame or under a restart strobe can only be shown by the bench scenarios. There, a behavioural model is compared against every output on every clock.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int SLOTS    = 4;

  typedef enum logic [1:0] {SL_VHI = 2'd0, SL_VLO = 2'd1, SL_CHI = 2'd2, SL_CLO = 2'd3} slot_e;

  // Most negative code is lifted by one
  function automatic logic [SAMPLE_W-1:0] clamp_neg(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] most_neg;
    most_neg = {1'b1, {(SAMPLE_W-1){1'b0}}};
    return (s == most_neg) ? (most_neg + 1'b1) : s;
  endfunction

  // Coarse magnitude of a high byte: one's complement when negative
  function automatic logic [BYTE_W-1:0] coarse_mag(input logic [BYTE_W-1:0] h);
    return h[BYTE_W-1] ? ~h : h;
  endfunction
endpackage

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 byte_valid,
  output logic                 acc,
  output logic [((NPH > 1) ? $clog2(NPH) : 1)-1:0] ph_idx,
  output slot_e                slot,
  output logic [NPH-1:0]       conv_sel,
  output logic                 frame_done
);
  localparam int TOTAL = NPH * SLOTS;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int PH_W  = (NPH > 1) ? $clog2(NPH) : 1;

  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             phase_end;
  logic             frame_end;

  assign acc       = busy && byte_valid && !frame_start;
  assign ph_idx    = PH_W'(cnt >> 2);
  assign slot      = slot_e'(cnt[1:0]);
  assign phase_end = acc && (slot == SL_CLO);
  assign frame_end = phase_end && (ph_idx == PH_W'(NPH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      busy       <= 1'b0;
      conv_sel   <= NPH'(1);
      frame_done <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (frame_start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        conv_sel <= NPH'(1);
      end else if (acc) begin
        cnt <= cnt + 1'b1;
        if (frame_end) busy <= 1'b0;
        if (phase_end) conv_sel <= frame_end ? NPH'(1) : (conv_sel << 1);
      end
    end
  end

  // R2: select always one-hot
  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(conv_sel) == 1);
  // R2: select moves only at a phase boundary or a restart
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !phase_end) |=> $stable(conv_sel));
  // R2: phase A reselected after the frame
  a_r2_sel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (conv_sel == NPH'(1)));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/pc_peak.sv
module pc_peak
  import pc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] pk
);
  logic [BYTE_W-1:0] mag;
  logic              raise;

  assign mag   = coarse_mag(hi);
  assign raise = upd && (mag > pk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pk <= '0;
    else if (clr)   pk <= '0;
    else if (raise) pk <= mag;
  end

  // R8: clear wins and zeroes the peak
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pk == '0));
  // R6: peak never shrinks without clear
  a_r6_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pk >= $past(pk)));
  // R6: after an update the peak covers the new magnitude
  a_r6_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (pk >= $past(mag)));
endmodule

// File: rtl/pc_channel.sv
module pc_channel
  import pc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  slot_e               slot,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                clr,
  output logic [SAMPLE_W-1:0] v_now,
  output logic [SAMPLE_W-1:0] c_now,
  output logic [SAMPLE_W-1:0] v_dly,
  output logic [SAMPLE_W-1:0] c_dly,
  output logic [BYTE_W-1:0]   pk_v,
  output logic [BYTE_W-1:0]   pk_c
);
  logic [BYTE_W-1:0]   stage;
  logic [SAMPLE_W-1:0] full;
  logic                first_byte;
  logic                wr_v;
  logic                wr_c;

  assign full       = clamp_neg({stage, rx_byte});
  assign first_byte = hit && (slot == SL_VHI);
  assign wr_v       = hit && (slot == SL_VLO);
  assign wr_c       = hit && (slot == SL_CLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      v_now <= '0;
      c_now <= '0;
      v_dly <= '0;
      c_dly <= '0;
    end else begin
      if (first_byte) begin
        v_dly <= v_now;
        c_dly <= c_now;
      end
      if (hit && (slot == SL_VHI || slot == SL_CHI)) stage <= rx_byte;
      if (wr_v) v_now <= full;
      if (wr_c) c_now <= full;
    end
  end

  pc_peak u_pk_v (.clk(clk), .rst_n(rst_n), .clr(clr), .upd(wr_v),
                  .hi(full[SAMPLE_W-1:BYTE_W]), .pk(pk_v));
  pc_peak u_pk_c (.clk(clk), .rst_n(rst_n), .clr(clr), .upd(wr_c),
                  .hi(full[SAMPLE_W-1:BYTE_W]), .pk(pk_c));

  // R3: delayed copy on the first byte of the phase
  a_r3_delay_copy: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |=> (v_dly == $past(v_now)) && (c_dly == $past(c_now)));
  // R5: most negative code never stored
  a_r5_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    (v_now != {1'b1, {(SAMPLE_W-1){1'b0}}}) && (c_now != {1'b1, {(SAMPLE_W-1){1'b0}}}));
  // R1: samples change only on their low byte
  a_r1_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_v |=> $stable(v_now));
  a_r1_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> $stable(c_now));
endmodule

// File: rtl/phase_cond_top.sv
module phase_cond_top
  import pc_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          byte_valid,
  input  logic [BYTE_W-1:0]             byte_in,
  input  logic                          test_en,
  input  logic [SAMPLE_W-1:0]           test_volt,
  input  logic [SAMPLE_W-1:0]           test_curr,
  input  logic                          peak_clr,
  output logic [NPH-1:0]                conv_sel,
  output logic [NPH-1:0][SAMPLE_W-1:0]  volt_now,
  output logic [NPH-1:0][SAMPLE_W-1:0]  curr_now,
  output logic [NPH-1:0][SAMPLE_W-1:0]  volt_dly,
  output logic [NPH-1:0][SAMPLE_W-1:0]  curr_dly,
  output logic [NPH-1:0][BYTE_W-1:0]    peak_volt,
  output logic [NPH-1:0][BYTE_W-1:0]    peak_curr,
  output logic                          frame_done
);
  localparam int PH_W = (NPH > 1) ? $clog2(NPH) : 1;

  logic            acc;
  logic [PH_W-1:0] ph_idx;
  slot_e           slot;
  logic [BYTE_W-1:0] test_byte;
  logic [BYTE_W-1:0] rx_byte;

  pc_sequencer #(.NPH(NPH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .acc(acc), .ph_idx(ph_idx), .slot(slot), .conv_sel(conv_sel), .frame_done(frame_done)
  );

  // Byte-wise test substitution
  always_comb begin
    case (slot)
      SL_VHI:  test_byte = test_volt[SAMPLE_W-1:BYTE_W];
      SL_VLO:  test_byte = test_volt[BYTE_W-1:0];
      SL_CHI:  test_byte = test_curr[SAMPLE_W-1:BYTE_W];
      default: test_byte = test_curr[BYTE_W-1:0];
    endcase
  end
  assign rx_byte = test_en ? test_byte : byte_in;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic hit;
    assign hit = acc && (ph_idx == PH_W'(g));
    pc_channel u_ch (
      .clk(clk), .rst_n(rst_n), .hit(hit), .slot(slot), .rx_byte(rx_byte), .clr(peak_clr),
      .v_now(volt_now[g]), .c_now(curr_now[g]), .v_dly(volt_dly[g]), .c_dly(curr_dly[g]),
      .pk_v(peak_volt[g]), .pk_c(peak_curr[g])
    );
  end
endmodule

// File: tb/tb_phase_cond_top.sv
module tb_phase_cond_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, byte_valid = 1'b0, test_en = 1'b0, peak_clr = 1'b0;
  logic [7:0] byte_in = '0;
  logic [15:0] test_volt = '0, test_curr = '0;
  logic [NPH-1:0] conv_sel;
  logic [NPH-1:0][15:0] volt_now, curr_now, volt_dly, curr_dly;
  logic [NPH-1:0][7:0] peak_volt, peak_curr;
  logic frame_done;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_cond_top #(.NPH(NPH)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_in(byte_in), .test_en(test_en), .test_volt(test_volt), .test_curr(test_curr),
    .peak_clr(peak_clr), .conv_sel(conv_sel), .volt_now(volt_now), .curr_now(curr_now),
    .volt_dly(volt_dly), .curr_dly(curr_dly), .peak_volt(peak_volt), .peak_curr(peak_curr),
    .frame_done(frame_done)
  );

  // Behavioural reference model
  int m_v[3], m_c[3], m_vd[3], m_cd[3], m_pv[3], m_pc[3];
  int m_sel, m_done, m_busy, m_cnt, m_stage;

  function automatic int mag_of(int w);
    int h;
    h = (w >> 8) & 255;
    return (h >= 128) ? 255 - h : h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++) begin
        m_v[p] = 0; m_c[p] = 0; m_vd[p] = 0; m_cd[p] = 0; m_pv[p] = 0; m_pc[p] = 0;
      end
      m_sel = 1; m_done = 0; m_busy = 0; m_cnt = 0; m_stage = 0;
    end else begin
      int ph, sl, b, w;
      m_done = 0;
      if (peak_clr)
        for (int p = 0; p < 3; p++) begin m_pv[p] = 0; m_pc[p] = 0; end
      if (frame_start) begin
        m_busy = 1; m_cnt = 0; m_sel = 1;
      end else if (m_busy != 0 && byte_valid) begin
        ph = m_cnt / 4; sl = m_cnt % 4;
        if (test_en) begin
          case (sl)
            0: b = (int'(test_volt) >> 8) & 255;
            1: b = int'(test_volt) & 255;
            2: b = (int'(test_curr) >> 8) & 255;
            default: b = int'(test_curr) & 255;
          endcase
        end else b = int'(byte_in);
        if (sl == 0) begin m_vd[ph] = m_v[ph]; m_cd[ph] = m_c[ph]; end
        if (sl == 0 || sl == 2) m_stage = b;
        if (sl == 1 || sl == 3) begin
          w = m_stage * 256 + b;
          if (w == 32768) w = 32769;
          if (sl == 1) begin
            m_v[ph] = w;
            if (!peak_clr && mag_of(w) > m_pv[ph]) m_pv[ph] = mag_of(w);
          end else begin
            m_c[ph] = w;
            if (!peak_clr && mag_of(w) > m_pc[ph]) m_pc[ph] = mag_of(w);
          end
        end
        if (sl == 3) begin
          m_sel = (ph == 2) ? 1 : (1 << (ph + 1));
          if (m_cnt == 11) begin m_done = 1; m_busy = 0; end
        end
        m_cnt++;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 conv_sel", int'(conv_sel), m_sel);
      check("R9 frame_done", int'(frame_done), m_done);
      for (int p = 0; p < 3; p++) begin
        check("R1 volt_now", int'(volt_now[p]), m_v[p]);
        check("R1 curr_now", int'(curr_now[p]), m_c[p]);
        check("R3 volt_dly", int'(volt_dly[p]), m_vd[p]);
        check("R3 curr_dly", int'(curr_dly[p]), m_cd[p]);
        check("R6 peak_volt", int'(peak_volt[p]), m_pv[p]);
        check("R6 peak_curr", int'(peak_curr[p]), m_pc[p]);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(int b);
    byte_valid = 1'b1; byte_in = 8'(b);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic frame(int v0, int c0, int v1, int c1, int v2, int c2, int gap);
    int w[6];
    w = '{v0, c0, v1, c1, v2, c2};
    start();
    for (int k = 0; k < 6; k++) begin
      send_byte((w[k] >> 8) & 255);
      if (gap > 0) tick(gap);
      send_byte(w[k] & 255);
      if (gap > 0 && k != 5) tick(gap);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 sel", int'(conv_sel), 1);
    check("R11 volt", int'(volt_now[0]), 0);
    check("R11 peak", int'(peak_curr[2]), 0);
    check("R11 done", int'(frame_done), 0);

    // R10 bytes outside a frame are ignored
    send_byte(8'h55); send_byte(8'h66);
    check("R10 idle bytes", int'(volt_now[0]), 0);

    // R1 / R5 / R7 first frame
    frame(16'h1234, 16'hFEDC, 16'h8000, 16'h7F00, 16'hC3A0, 16'h0050, 0);
    check("R9 done after frame", int'(frame_done), 1);
    check("R1 phase C voltage", int'(volt_now[2]), 16'hC3A0);
    check("R5 clamp", int'(volt_now[1]), 16'h8001);
    check("R7 peak A cur", int'(peak_curr[0]), 8'h01);
    check("R7 peak B volt", int'(peak_volt[1]), 8'h7F);
    check("R7 peak C volt", int'(peak_volt[2]), 8'h3C);
    tick(1);
    check("R9 done drops", int'(frame_done), 0);

    // R3 second frame with gaps, check select mid-frame (R2)
    start();
    send_byte(8'h20); send_byte(8'h01); send_byte(8'h80); send_byte(8'h00);
    check("R2 sel after phase A", int'(conv_sel), 2);
    check("R3 delayed A volt", int'(volt_dly[0]), 16'h1234);
    check("R5 clamp current", int'(curr_now[0]), 16'h8001);
    for (int k = 0; k < 8; k++) begin send_byte(8'h10 + k); tick(2); end
    check("R2 sel wrap", int'(conv_sel), 1);
    check("R3 delayed C cur", int'(curr_dly[2]), 16'h0050);

    // R4 substitution, toggled byte by byte in a second part
    test_en = 1'b1; test_volt = 16'hA55A; test_curr = 16'h0102;
    frame(0, 0, 0, 0, 0, 0, 1);
    check("R4 test volt", int'(volt_now[1]), 16'hA55A);
    check("R4 test curr", int'(curr_now[2]), 16'h0102);
    start();
    test_en = 1'b0; send_byte(8'h33);
    test_en = 1'b1; send_byte(8'h44);
    test_en = 1'b0;
    check("R4 mixed bytes", int'(volt_now[0]), 16'h335A);

    // R10 restart mid-frame, and byte with start in the same cycle
    send_byte(8'h77);
    frame_start = 1'b1; byte_valid = 1'b1; byte_in = 8'h99;
    @(negedge clk);
    frame_start = 1'b0; byte_valid = 1'b0;
    send_byte(8'hF0); send_byte(8'h0F);
    check("R10 restart", int'(volt_now[0]), 16'hF00F);
    check("R10 restart sel", int'(conv_sel), 1);

    // R8 clear colliding with an update
    peak_clr = 1'b1; send_byte(8'h70); send_byte(8'h00);
    peak_clr = 1'b0;
    check("R8 clear wins", int'(peak_curr[0]), 0);
    check("R8 clear others", int'(peak_volt[2]), 0);
    for (int k = 0; k < 8; k++) send_byte(8'hE0 + k);
    check("R7 peak after clear", int'(peak_volt[1]), 8'h1F);
    tick(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule